// File: doc/BRIEF.md
# Frame-Relative Load/Store and Stack Unit

This unit carries out the data-movement instructions of a 16-bit stack machine. It owns an eight-entry evaluation stack and its pointer. It moves words between that stack and memory, and it forms the less usual immediate constants of the machine. Memory words are addressed as a frame base plus an operand byte. Two frame bases are supplied: one for locals and one for globals. Memory is reached through a single word-wide port that holds its request until the memory acknowledges it.

An instruction is issued by pulsing `start_i` for one cycle. The pulse carries a 5-bit opcode and up to two operand bytes, alpha and beta. The unit completes each instruction with a one-cycle `done_o` pulse. The stack depth and the two topmost entries are always visible on the outputs.

An instruction that would take the stack past eight entries, or below zero, has no effect at all. Instead it raises a sticky error flag.

Top module: `lsu_top`

## Requirements
- R1: While reset is held, and until the first instruction, the depth is 0, the error flag is 0, done is 0 and no memory request is made.
- R2: Opcodes 0 (local) and 1 (global) read the word at base+alpha and push it.
- R3: Opcodes 2 (local) and 3 (global) pop the top entry and write it to base+alpha.
- R4: Opcode 4 writes the top entry to local base+alpha. The entry stays on the stack, so the depth is unchanged.
- R5: Opcode 5 pushes alpha zero-extended. Opcode 6 pushes 0xFFFF. Opcode 7 pushes 0x8000.
- R6: Opcode 8 pushes 0xFF00 OR alpha for every alpha. Alpha is never sign-extended.
- R7: Opcode 9 pushes alpha*256 + beta.
- R8: Opcodes 10 (local) and 11 (global) push the word at base+alpha first and then the word at base+alpha+1. The second word ends up on top.
- R9: Opcodes 12 (local) and 13 (global) pop the top entry into base+alpha+1, then pop the next entry into base+alpha.
- R10: Opcode 17 swaps the top two entries. Opcode 16 pushes a copy of the top entry.
- R11: Opcode 14 raises the depth by one and opcode 15 lowers it by one. Neither one changes any entry, so raising the depth after lowering it brings back the value that was on top.
- R12: An instruction that needs more entries than are present, or that would push past 8, sets the error flag. The flag stays set until reset. The instruction changes neither the stack nor memory, and it makes no memory request.
- R13: Every start taken while idle ends in exactly one single-cycle done pulse. A start that arrives while a memory access is in progress is ignored. A memory request is held until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction strobe |
| op_i | input | 5 | Opcode |
| alpha_i | input | 8 | First operand byte |
| beta_i | input | 8 | Second operand byte |
| lbase_i | input | AW | Local frame base |
| gbase_i | input | AW | Global frame base |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Read valid or write accepted |
| done_o | output | 1 | Instruction complete pulse |
| depth_o | output | PW | Number of stack entries |
| tos_o | output | 16 | Top entry (0 when empty) |
| nos_o | output | 16 | Entry below the top (0 when fewer than two) |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench sweeps every alpha through the negative-byte immediate. A design that sign-extends would return 0x00xx for alpha below 0x80, and the sweep catches that. It also walks many alpha/beta pairs through the word immediate, where a design with the bytes swapped would miscompare.

The double transfers are run against a memory of distinct words. A design that pushes the two words in the wrong order, or stores the top entry to the lower address, leaves the stack or memory image different from the model. Put is checked for a depth that does not change and for exactly one write. Pointer-only lowering followed by raising must bring back the earlier top entry. A design that clears entries would lose it.

Overflow and underflow attempts are checked for an unchanged depth, top entry and write count, and for the error flag staying set. A start issued during a memory access must leave no trace.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DW = 16;

  typedef enum logic [4:0] {
    OP_LDL    = 5'd0,
    OP_LDG    = 5'd1,
    OP_STL    = 5'd2,
    OP_STG    = 5'd3,
    OP_PUTL   = 5'd4,
    OP_LIMM   = 5'd5,
    OP_LNEG1  = 5'd6,
    OP_LNINF  = 5'd7,
    OP_LNBYTE = 5'd8,
    OP_LWORD  = 5'd9,
    OP_LDDL   = 5'd10,
    OP_LDDG   = 5'd11,
    OP_STDL   = 5'd12,
    OP_STDG   = 5'd13,
    OP_PUSHP  = 5'd14,
    OP_POPP   = 5'd15,
    OP_DUP    = 5'd16,
    OP_EXCH   = 5'd17
  } op_e;

  typedef enum logic [2:0] {SC_NONE, SC_PUSH, SC_POP, SC_INC, SC_SWAP} stk_cmd_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC1, ST_ACC2} fsm_e;
endpackage

// File: rtl/lsu_stack.sv
module lsu_stack
  import lsu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_cmd_e      cmd,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] depth,
  output logic [DW-1:0] tos,
  output logic [DW-1:0] nos
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] ent [DEPTH];
  logic [PW-1:0] sp_q, sp_d;
  logic [IW-1:0] top_idx, sec_idx, ins_idx;

  assign top_idx = IW'(sp_q - PW'(1));
  assign sec_idx = IW'(sp_q - PW'(2));
  assign ins_idx = IW'(sp_q);

  always_comb begin
    sp_d = sp_q;
    case (cmd)
      SC_PUSH, SC_INC: sp_d = sp_q + PW'(1);
      SC_POP:          sp_d = sp_q - PW'(1);
      default:         sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (cmd != SC_NONE) sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (cmd == SC_PUSH && ins_idx == IW'(i))
        ent[i] <= wdata;
      else if (cmd == SC_SWAP && top_idx == IW'(i))
        ent[i] <= ent[sec_idx];
      else if (cmd == SC_SWAP && sec_idx == IW'(i))
        ent[i] <= ent[top_idx];
    end
  end

  assign depth = sp_q;
  assign tos   = (sp_q != '0)       ? ent[top_idx] : '0;
  assign nos   = (sp_q >= PW'(2))   ? ent[sec_idx] : '0;
endmodule

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int AW = 16
) (
  input  op_e           new_op,
  input  logic [7:0]    alpha,
  input  logic [7:0]    beta,
  input  op_e           cur_op,
  input  logic [7:0]    cur_alpha,
  input  logic [AW-1:0] lbase,
  input  logic [AW-1:0] gbase,
  input  logic          second,
  output logic [DW-1:0] imm,
  output logic [1:0]    need,
  output logic [1:0]    grow,
  output logic          new_mem,
  output logic [AW-1:0] addr,
  output logic          cur_load,
  output logic          cur_pop,
  output logic          cur_we,
  output logic          cur_dbl
);
  logic          use_g, plus1;
  logic [AW-1:0] base;

  always_comb begin
    imm = '0;
    case (new_op)
      OP_LIMM:   imm = {8'h00, alpha};
      OP_LNEG1:  imm = 16'hFFFF;
      OP_LNINF:  imm = 16'h8000;
      OP_LNBYTE: imm = {8'hFF, alpha};
      OP_LWORD:  imm = {alpha, beta};
      default:   imm = '0;
    endcase
  end

  always_comb begin
    need = 2'd0; grow = 2'd0; new_mem = 1'b0;
    case (new_op)
      OP_LDL, OP_LDG:              begin grow = 2'd1; new_mem = 1'b1; end
      OP_STL, OP_STG, OP_PUTL:     begin need = 2'd1; new_mem = 1'b1; end
      OP_LDDL, OP_LDDG:            begin grow = 2'd2; new_mem = 1'b1; end
      OP_STDL, OP_STDG:            begin need = 2'd2; new_mem = 1'b1; end
      OP_LIMM, OP_LNEG1, OP_LNINF,
      OP_LNBYTE, OP_LWORD, OP_PUSHP: grow = 2'd1;
      OP_POPP:                     need = 2'd1;
      OP_DUP:                      begin need = 2'd1; grow = 2'd1; end
      OP_EXCH:                     need = 2'd2;
      default:                     ;
    endcase
  end

  always_comb begin
    cur_load = 1'b0; cur_pop = 1'b0; cur_we = 1'b0; cur_dbl = 1'b0; use_g = 1'b0;
    case (cur_op)
      OP_LDL:  cur_load = 1'b1;
      OP_LDG:  begin cur_load = 1'b1; use_g = 1'b1; end
      OP_STL:  begin cur_pop = 1'b1; cur_we = 1'b1; end
      OP_STG:  begin cur_pop = 1'b1; cur_we = 1'b1; use_g = 1'b1; end
      OP_PUTL: cur_we = 1'b1;
      OP_LDDL: begin cur_load = 1'b1; cur_dbl = 1'b1; end
      OP_LDDG: begin cur_load = 1'b1; cur_dbl = 1'b1; use_g = 1'b1; end
      OP_STDL: begin cur_pop = 1'b1; cur_we = 1'b1; cur_dbl = 1'b1; end
      OP_STDG: begin cur_pop = 1'b1; cur_we = 1'b1; cur_dbl = 1'b1; use_g = 1'b1; end
      default: ;
    endcase
  end

  // loads walk upward, stores walk downward from alpha+1
  assign plus1 = cur_dbl & (cur_load ? second : ~second);
  assign base  = use_g ? gbase : lbase;
  assign addr  = base + AW'(cur_alpha) + AW'(plus1);
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int AW    = 16,
  localparam int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [4:0]    op_i,
  input  logic [7:0]    alpha_i,
  input  logic [7:0]    beta_i,
  input  logic [AW-1:0] lbase_i,
  input  logic [AW-1:0] gbase_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          done_o,
  output logic [PW-1:0] depth_o,
  output logic [DW-1:0] tos_o,
  output logic [DW-1:0] nos_o,
  output logic          err_o
);
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  fsm_e          state_q, state_d;
  op_e           op_q, new_op;
  logic [7:0]    alpha_q;
  logic          err_q, err_d, done_q, done_d, cap_en;
  stk_cmd_e      cmd;
  logic [DW-1:0] cmd_data, imm, tos, nos;
  logic [PW-1:0] depth;
  logic [1:0]    need, grow;
  logic          new_mem, cur_load, cur_pop, cur_we, cur_dbl, legal, second;
  logic [AW-1:0] addr;

  assign new_op = op_e'(op_i);
  assign second = (state_q == ST_ACC2);

  lsu_decode #(.AW(AW)) u_dec (
    .new_op(new_op), .alpha(alpha_i), .beta(beta_i),
    .cur_op(op_q), .cur_alpha(alpha_q), .lbase(lbase_i), .gbase(gbase_i),
    .second(second), .imm(imm), .need(need), .grow(grow), .new_mem(new_mem),
    .addr(addr), .cur_load(cur_load), .cur_pop(cur_pop), .cur_we(cur_we),
    .cur_dbl(cur_dbl)
  );

  lsu_stack #(.DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk(clk), .rst_n(rst_s), .cmd(cmd), .wdata(cmd_data),
    .depth(depth), .tos(tos), .nos(nos)
  );

  assign legal = (int'(depth) >= int'(need)) && (int'(depth) + int'(grow) <= DEPTH);

  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    done_d   = 1'b0;
    cmd      = SC_NONE;
    cmd_data = imm;
    cap_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!legal) begin
            err_d  = 1'b1;
            done_d = 1'b1;
          end else if (new_mem) begin
            state_d = ST_ACC1;
            cap_en  = 1'b1;
          end else begin
            done_d = 1'b1;
            case (new_op)
              OP_LIMM, OP_LNEG1, OP_LNINF, OP_LNBYTE, OP_LWORD: cmd = SC_PUSH;
              OP_DUP:   begin cmd = SC_PUSH; cmd_data = tos; end
              OP_PUSHP: cmd = SC_INC;
              OP_POPP:  cmd = SC_POP;
              OP_EXCH:  cmd = SC_SWAP;
              default:  cmd = SC_NONE;
            endcase
          end
        end
      end
      ST_ACC1, ST_ACC2: begin
        if (mem_ack_i) begin
          if (cur_load) begin
            cmd      = SC_PUSH;
            cmd_data = mem_rdata_i;
          end else if (cur_pop) begin
            cmd = SC_POP;
          end
          if (cur_dbl && state_q == ST_ACC1) begin
            state_d = ST_ACC2;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      op_q    <= new_op;
      alpha_q <= alpha_i;
    end
  end

  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = mem_req_o & cur_we;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = tos;
  assign done_o      = done_q;
  assign depth_o     = depth;
  assign tos_o       = tos;
  assign nos_o       = nos;
  assign err_o       = err_q;
endmodule

// File: rtl/lsu_chk.sv
module lsu_chk #(
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          req,
  input logic          ack,
  input logic          err,
  input logic [PW-1:0] depth
);
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth) <= DEPTH); // R12

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R12

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !req); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req); // R13

  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(depth) |-> (depth == $past(depth) + PW'(1) || depth == $past(depth) - PW'(1))); // R11
endmodule

bind lsu_top lsu_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done_o), .req(mem_req_o),
  .ack(mem_ack_i), .err(err_o), .depth(depth_o)
);

// File: tb/sim_lsu_top.sv
`timescale 1ns/1ps
module sim_lsu_top;
  import lsu_pkg::*;

  localparam logic [15:0] LB = 16'h0010;
  localparam logic [15:0] GB = 16'h0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [7:0]  alpha_i = '0, beta_i = '0;
  logic        mem_req_o, mem_we_o, mem_ack_i, done_o, err_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i, tos_o, nos_o;
  logic [3:0]  depth_o;

  always #2.5 clk = ~clk;

  lsu_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .alpha_i(alpha_i), .beta_i(beta_i), .lbase_i(LB), .gbase_i(GB),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .done_o(done_o), .depth_o(depth_o), .tos_o(tos_o), .nos_o(nos_o), .err_o(err_o)
  );

  // bench memory
  logic [15:0] bm [256];
  int          wcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack_i <= 1'b0;
    end else if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   <= 1'b1;
      mem_rdata_i <= bm[mem_addr_o[7:0]];
      if (mem_we_o) begin
        bm[mem_addr_o[7:0]] <= mem_wdata_o;
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack_i <= 1'b0;
    end
  end

  // reference model
  logic [15:0] rs [8];
  logic [15:0] rm [256];
  int          rd, exp_wr;
  logic        rerr;
  int          nvec, nfail;
  bit          finished;

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic string tag(input op_e op);
    case (op)
      OP_LDL, OP_LDG:                       return "R2";
      OP_STL, OP_STG:                       return "R3";
      OP_PUTL:                              return "R4";
      OP_LIMM, OP_LNEG1, OP_LNINF:          return "R5";
      OP_LNBYTE:                            return "R6";
      OP_LWORD:                             return "R7";
      OP_LDDL, OP_LDDG:                     return "R8";
      OP_STDL, OP_STDG:                     return "R9";
      OP_DUP, OP_EXCH:                      return "R10";
      default:                              return "R11";
    endcase
  endfunction

  task automatic mpush(input logic [15:0] v);
    rs[rd] = v; rd++;
  endtask

  task automatic model(input op_e op, input logic [7:0] a, input logic [7:0] b);
    int need, grow;
    logic [7:0] la, ga;
    logic [15:0] t;
    la = 8'(LB + 16'(a));
    ga = 8'(GB + 16'(a));
    need = 0; grow = 0;
    case (op)
      OP_LDL, OP_LDG, OP_LIMM, OP_LNEG1, OP_LNINF, OP_LNBYTE, OP_LWORD, OP_PUSHP: grow = 1;
      OP_STL, OP_STG, OP_PUTL, OP_POPP: need = 1;
      OP_LDDL, OP_LDDG: grow = 2;
      OP_STDL, OP_STDG, OP_EXCH: need = 2;
      OP_DUP: begin need = 1; grow = 1; end
      default: ;
    endcase
    if (rd < need || rd + grow > 8) begin
      rerr = 1'b1;
    end else begin
      case (op)
        OP_LDL:    mpush(rm[la]);
        OP_LDG:    mpush(rm[ga]);
        OP_STL:    begin rd--; rm[la] = rs[rd]; exp_wr++; end
        OP_STG:    begin rd--; rm[ga] = rs[rd]; exp_wr++; end
        OP_PUTL:   begin rm[la] = rs[rd-1]; exp_wr++; end
        OP_LIMM:   mpush(16'(a));
        OP_LNEG1:  mpush(16'd65535);
        OP_LNINF:  mpush(16'd32768);
        OP_LNBYTE: mpush(16'd65280 | 16'(a));
        OP_LWORD:  mpush(16'(int'(a) * 256 + int'(b)));
        OP_LDDL:   begin mpush(rm[la]); mpush(rm[8'(la + 8'd1)]); end
        OP_LDDG:   begin mpush(rm[ga]); mpush(rm[8'(ga + 8'd1)]); end
        OP_STDL:   begin rm[8'(la + 8'd1)] = rs[rd-1]; rm[la] = rs[rd-2]; rd -= 2; exp_wr += 2; end
        OP_STDG:   begin rm[8'(ga + 8'd1)] = rs[rd-1]; rm[ga] = rs[rd-2]; rd -= 2; exp_wr += 2; end
        OP_PUSHP:  rd++;
        OP_POPP:   rd--;
        OP_DUP:    mpush(rs[rd-1]);
        OP_EXCH:   begin t = rs[rd-1]; rs[rd-1] = rs[rd-2]; rs[rd-2] = t; end
        default: ;
      endcase
    end
  endtask

  task automatic finish_op(input op_e op);
    int n;
    string r;
    bit memok;
    r = tag(op);
    n = 0;
    while (!done_o && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R13", 16'(done_o), 16'd1);
    chk(r, 16'(depth_o), 16'(rd));
    if (rd > 0 && !$isunknown(rs[rd-1])) chk(r, tos_o, rs[rd-1]);
    if (rd > 1 && !$isunknown(rs[rd-2])) chk(r, nos_o, rs[rd-2]);
    chk("R12", 16'(err_o), 16'(rerr));
    chk(r, 16'(wcnt), 16'(exp_wr));
    if (op inside {OP_STL, OP_STG, OP_PUTL, OP_STDL, OP_STDG}) begin
      memok = 1'b1;
      for (int i = 0; i < 256; i++) if (bm[i] !== rm[i]) memok = 1'b0;
      chk(r, 16'(memok), 16'd1);
    end
    @(negedge clk);
    chk("R13", 16'(done_o), 16'd0);
  endtask

  task automatic do_op(input op_e op, input logic [7:0] a = 8'd0, input logic [7:0] b = 8'd0);
    model(op, a, b);
    op_i = op; alpha_i = a; beta_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_op(op);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    nvec = 0; nfail = 0; rd = 0; exp_wr = 0; rerr = 1'b0; wcnt = 0; finished = 0;
    for (int i = 0; i < 256; i++) begin
      bm[i] = 16'(i * 291) ^ 16'hA5C3;
      rm[i] = bm[i];
    end
    for (int i = 0; i < 8; i++) rs[i] = 'x;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk("R1", 16'(depth_o), 16'd0);
    chk("R1", 16'(err_o), 16'd0);
    chk("R1", 16'(done_o), 16'd0);
    chk("R1", 16'(mem_req_o), 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 16'(depth_o), 16'd0);
    chk("R1", 16'(mem_req_o), 16'd0);

    // R6 full alpha sweep
    for (int a = 0; a < 256; a++) begin do_op(OP_LNBYTE, 8'(a)); do_op(OP_POPP); end
    // R7 word immediate sweep
    for (int a = 0; a < 256; a++) begin do_op(OP_LWORD, 8'(a), 8'(a * 37 + 11)); do_op(OP_POPP); end
    // R5 constants
    for (int a = 0; a < 256; a += 17) begin do_op(OP_LIMM, 8'(a)); do_op(OP_POPP); end
    do_op(OP_LNEG1); do_op(OP_LNINF); do_op(OP_POPP); do_op(OP_POPP);
    // R2 / R3 frame loads and stores
    for (int a = 0; a < 32; a++) begin
      do_op(OP_LDL, 8'(a)); do_op(OP_STG, 8'(a + 32));
      do_op(OP_LDG, 8'(a)); do_op(OP_STL, 8'(a + 64));
    end
    // R4 put keeps the entry
    for (int a = 0; a < 16; a++) begin
      do_op(OP_LIMM, 8'(a * 9 + 1)); do_op(OP_PUTL, 8'(a + 160)); do_op(OP_POPP);
    end
    // R8 / R9 double transfers
    for (int a = 0; a < 16; a++) begin
      do_op(OP_LDDG, 8'(a)); do_op(OP_STDL, 8'(a * 2 + 48));
      do_op(OP_LDDL, 8'(a)); do_op(OP_STDG, 8'(a * 2 + 64));
    end
    // R10 exchange and duplicate
    do_op(OP_LIMM, 8'h01); do_op(OP_LIMM, 8'h02);
    do_op(OP_EXCH); do_op(OP_DUP); do_op(OP_EXCH);
    do_op(OP_POPP); do_op(OP_POPP); do_op(OP_POPP);
    // R11 pointer-only moves re-expose old values
    do_op(OP_LIMM, 8'h33); do_op(OP_LIMM, 8'h44);
    do_op(OP_POPP); do_op(OP_PUSHP); do_op(OP_POPP); do_op(OP_POPP);
    do_op(OP_PUSHP); do_op(OP_PUSHP); do_op(OP_POPP); do_op(OP_POPP);
    // R13 start while busy is ignored
    model(OP_LDL, 8'd5, 8'd0);
    op_i = OP_LDL; alpha_i = 8'd5; start_i = 1'b1;
    @(negedge clk);
    op_i = OP_LIMM; alpha_i = 8'h77;
    @(negedge clk);
    start_i = 1'b0;
    finish_op(OP_LDL);
    do_op(OP_POPP);
    // R12 underflow, overflow and stickiness
    chk("R12", 16'(err_o), 16'd0);
    do_op(OP_POPP); do_op(OP_STL, 8'd3); do_op(OP_STDG, 8'd3);
    do_op(OP_LIMM, 8'h5A); do_op(OP_EXCH);
    for (int i = 0; i < 6; i++) do_op(OP_LIMM, 8'(i + 100));
    do_op(OP_LDDL, 8'd0);
    do_op(OP_DUP);
    do_op(OP_LIMM, 8'hEE); do_op(OP_LDG, 8'd1); do_op(OP_PUSHP);
    do_op(OP_STDL, 8'd200);
    chk("R12", 16'(depth_o), 16'd6);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule